// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block passes an 18-bit word between two ports, A and B. Each direction has its own storage element. That element works as a transparent latch while its pass control is high. While the pass control is low it works as an edge-triggered register. The register loads on a rising edge of the direction's strobe input, and only when the direction's active-low strobe enable is low at that edge. Each direction also has an active-low drive control. The shared pins are modelled as a data-out bus plus a drive-enable flag. The pad ring or a higher level puts the tri-state on the pins from these two signals.

The block lives in a synchronous domain clocked by `clk_i`. The strobe inputs are sampled on that clock, and a strobe edge is a sampled low followed by a sampled high. In pass mode the output follows the input combinationally. The stored word is the input seen at the last clock edge while pass was high. The A-to-B direction drives the B port. The B-to-A direction drives the A port and mirrors A-to-B exactly, with its own controls.

Top module: `bus_xcvr_latreg`

## Requirements
- R1: The data width is the parameter `WIDTH`, default 18, and it applies to both directions.
- R2: While a direction's pass input is high, its data output equals its data input in the same cycle.
- R3: While pass is low and no qualified strobe edge occurs, the data output holds its value. This covers the strobe held static high, held static low, or toggled with the enable inactive.
- R4: With pass low, a strobe sampled low at one clock edge and high at the next is a qualified edge if the strobe enable is low at that second edge. A qualified edge loads the data input sampled at that edge, and the output shows the loaded word after the edge.
- R5: A strobe edge while the strobe enable is high (inactive) leaves the stored word unchanged.
- R6: A direction's drive output is high exactly when its drive control input is low.
- R7: The B-to-A direction obeys R2 to R6 with its own inputs, independently of the A-to-B direction.
- R8: After reset both stored words are zero, and a strobe already high when reset is released is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_data_i | input | WIDTH | Word arriving on port A |
| a_data_o | output | WIDTH | Word driven onto port A (B-to-A path) |
| a_drive_o | output | 1 | Port A drive enable |
| b_data_i | input | WIDTH | Word arriving on port B |
| b_data_o | output | WIDTH | Word driven onto port B (A-to-B path) |
| b_drive_o | output | 1 | Port B drive enable |
| ab_pass_i | input | 1 | A-to-B pass (transparent) select |
| ab_strobe_i | input | 1 | A-to-B load strobe |
| ab_strobe_en_ni | input | 1 | A-to-B strobe enable, active low |
| ab_drive_ni | input | 1 | A-to-B drive control, active low |
| ba_pass_i | input | 1 | B-to-A pass (transparent) select |
| ba_strobe_i | input | 1 | B-to-A load strobe |
| ba_strobe_en_ni | input | 1 | B-to-A strobe enable, active low |
| ba_drive_ni | input | 1 | B-to-A drive control, active low |

## Verification
The bench builds the block at the default `WIDTH` of 18. At that width, all-ones, alternating and single-bit patterns reach the top bit, so a dropped or shifted bit shows up. The same directed scenarios run once per direction: pass, hold with the strobe static, qualified load, gated strobe edge and drive control. This catches a cross-wired control between the two paths. One scenario enables both drives together. The bench reports the bus conflict there and checks only the drive flags, not resolved data.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int NUM_DIR = 2;
  localparam int DIR_AB  = 0;
  localparam int DIR_BA  = 1;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_PASS = 2'd1,
    MODE_LOAD = 2'd2
  } mode_e;
endpackage

// File: rtl/xcvr_edge_detect.sv
module xcvr_edge_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic strobe_en_ni,
  output logic qual_rise_o
);
  logic strobe_q;

  // reset high: a strobe already high at release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b1;
    else         strobe_q <= strobe_i;
  end

  assign qual_rise_o = strobe_i & ~strobe_q & ~strobe_en_ni;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else begin
      unique case (mode_i)
        MODE_PASS, MODE_LOAD: q_o <= d_i;
        default:              q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pass_i,
  input  logic             strobe_i,
  input  logic             strobe_en_ni,
  input  logic             drive_ni,
  output logic [WIDTH-1:0] dout_o,
  output logic             drive_o
);
  logic             qual_rise;
  mode_e            mode;
  logic [WIDTH-1:0] stored;

  xcvr_edge_detect u_edge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .strobe_i     (strobe_i),
    .strobe_en_ni (strobe_en_ni),
    .qual_rise_o  (qual_rise)
  );

  // pass has priority over a strobe edge
  always_comb begin
    if (pass_i)         mode = MODE_PASS;
    else if (qual_rise) mode = MODE_LOAD;
    else                mode = MODE_HOLD;
  end

  xcvr_store #(.WIDTH(WIDTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .d_i    (din_i),
    .q_o    (stored)
  );

  assign dout_o  = pass_i ? din_i : stored;
  assign drive_o = ~drive_ni;
endmodule

// File: rtl/bus_xcvr_latreg.sv
module bus_xcvr_latreg
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_data_i,
  output logic [WIDTH-1:0] a_data_o,
  output logic             a_drive_o,
  input  logic [WIDTH-1:0] b_data_i,
  output logic [WIDTH-1:0] b_data_o,
  output logic             b_drive_o,
  input  logic             ab_pass_i,
  input  logic             ab_strobe_i,
  input  logic             ab_strobe_en_ni,
  input  logic             ab_drive_ni,
  input  logic             ba_pass_i,
  input  logic             ba_strobe_i,
  input  logic             ba_strobe_en_ni,
  input  logic             ba_drive_ni
);
  logic [WIDTH-1:0] din_s    [NUM_DIR];
  logic [WIDTH-1:0] dout_s   [NUM_DIR];
  logic             pass_s   [NUM_DIR];
  logic             strobe_s [NUM_DIR];
  logic             sten_s   [NUM_DIR];
  logic             drvn_s   [NUM_DIR];
  logic             drv_s    [NUM_DIR];

  assign din_s[DIR_AB]    = a_data_i;
  assign pass_s[DIR_AB]   = ab_pass_i;
  assign strobe_s[DIR_AB] = ab_strobe_i;
  assign sten_s[DIR_AB]   = ab_strobe_en_ni;
  assign drvn_s[DIR_AB]   = ab_drive_ni;

  assign din_s[DIR_BA]    = b_data_i;
  assign pass_s[DIR_BA]   = ba_pass_i;
  assign strobe_s[DIR_BA] = ba_strobe_i;
  assign sten_s[DIR_BA]   = ba_strobe_en_ni;
  assign drvn_s[DIR_BA]   = ba_drive_ni;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    xcvr_path #(.WIDTH(WIDTH)) u_path (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .din_i        (din_s[g]),
      .pass_i       (pass_s[g]),
      .strobe_i     (strobe_s[g]),
      .strobe_en_ni (sten_s[g]),
      .drive_ni     (drvn_s[g]),
      .dout_o       (dout_s[g]),
      .drive_o      (drv_s[g])
    );
  end

  assign b_data_o  = dout_s[DIR_AB];
  assign b_drive_o = drv_s[DIR_AB];
  assign a_data_o  = dout_s[DIR_BA];
  assign a_drive_o = drv_s[DIR_BA];
endmodule

// File: rtl/bus_xcvr_latreg_chk.sv
module bus_xcvr_latreg_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] din_i,
  input logic             pass_i,
  input logic             strobe_i,
  input logic             strobe_en_ni,
  input logic             drive_ni,
  input logic [WIDTH-1:0] dout_i,
  input logic             drive_i
);
  logic strobe_prev;
  logic qual;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_prev <= 1'b1;
    else         strobe_prev <= strobe_i;
  end

  assign qual = ~pass_i & strobe_i & ~strobe_prev & ~strobe_en_ni;

  // R2 / R7 (per bound direction)
  p_pass_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_i |-> dout_i == din_i);

  // R3, R5: no update without pass or qualified edge
  p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pass_i && !$past(pass_i) && !$past(qual)) |-> $stable(dout_i));

  p_load_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual ##1 !pass_i |-> dout_i == $past(din_i));

  p_gated_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pass_i && strobe_i && !strobe_prev && strobe_en_ni) ##1 !pass_i
      |-> $stable(dout_i));

  p_drive_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_ni |-> drive_i);

  p_drive_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_ni |-> !drive_i);
endmodule

bind bus_xcvr_latreg bus_xcvr_latreg_chk #(.WIDTH(WIDTH)) u_chk_ab (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .din_i        (a_data_i),
  .pass_i       (ab_pass_i),
  .strobe_i     (ab_strobe_i),
  .strobe_en_ni (ab_strobe_en_ni),
  .drive_ni     (ab_drive_ni),
  .dout_i       (b_data_o),
  .drive_i      (b_drive_o)
);

// R7: same properties on the reverse direction
bind bus_xcvr_latreg bus_xcvr_latreg_chk #(.WIDTH(WIDTH)) u_chk_ba (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .din_i        (b_data_i),
  .pass_i       (ba_pass_i),
  .strobe_i     (ba_strobe_i),
  .strobe_en_ni (ba_strobe_en_ni),
  .drive_ni     (ba_drive_ni),
  .dout_i       (a_data_o),
  .drive_i      (a_drive_o)
);

// File: tb/bus_xcvr_latreg_tb_top.sv
`timescale 1ns/1ps
module bus_xcvr_latreg_tb_top;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_drv, b_drv;
  logic         ab_pass = 0, ab_stb = 0, ab_en_n = 1, ab_drv_n = 1;
  logic         ba_pass = 0, ba_stb = 0, ba_en_n = 1, ba_drv_n = 1;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  bus_xcvr_latreg #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .a_data_i(a_in), .a_data_o(a_out), .a_drive_o(a_drv),
    .b_data_i(b_in), .b_data_o(b_out), .b_drive_o(b_drv),
    .ab_pass_i(ab_pass), .ab_strobe_i(ab_stb),
    .ab_strobe_en_ni(ab_en_n), .ab_drive_ni(ab_drv_n),
    .ba_pass_i(ba_pass), .ba_strobe_i(ba_stb),
    .ba_strobe_en_ni(ba_en_n), .ba_drive_ni(ba_drv_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_in(input int d, input logic [W-1:0] v);
    if (d == 0) a_in = v; else b_in = v;
  endtask

  task automatic set_ctl(input int d, input logic p, input logic s, input logic en_n);
    if (d == 0) begin ab_pass = p; ab_stb = s; ab_en_n = en_n; end
    else        begin ba_pass = p; ba_stb = s; ba_en_n = en_n; end
  endtask

  function automatic logic [W-1:0] get_out(input int d);
    return (d == 0) ? b_out : a_out;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    // R8: zero after reset; strobe high at release is no edge
    ab_stb = 1; ab_en_n = 0; a_in = 18'h2AAAA;
    repeat (2) tick();
    rst_n = 1;
    repeat (2) tick();
    chk("R8 ab reset", b_out, '0);
    chk("R8 ba reset", a_out, '0);
    ab_stb = 0; ab_en_n = 1; a_in = '0;
  endtask

  task automatic t_pass(input int d);
    logic [W-1:0] pats [4] = '{18'h3FFFF, 18'h15555, 18'h20000, 18'h00001};
    foreach (pats[i]) begin
      tick();
      set_ctl(d, 1, 0, 1);
      set_in(d, pats[i]);
      #1;
      chk(d == 0 ? "R2 ab pass" : "R7 ba pass", get_out(d), pats[i]);
    end
  endtask

  task automatic t_hold(input int d);
    tick(); set_ctl(d, 1, 0, 1); set_in(d, 18'h1A5C3);
    tick(); set_ctl(d, 0, 0, 1); set_in(d, 18'h0F0F0);
    repeat (3) tick();
    chk(d == 0 ? "R3 ab hold low" : "R7 ba hold low", get_out(d), 18'h1A5C3);
    set_ctl(d, 0, 1, 1);
    tick(); set_in(d, 18'h33333);
    repeat (3) tick();
    chk(d == 0 ? "R3 ab hold high" : "R7 ba hold high", get_out(d), 18'h1A5C3);
  endtask

  task automatic t_load(input int d);
    tick(); set_ctl(d, 0, 0, 0); set_in(d, 18'h2B6D1);
    tick(); set_ctl(d, 0, 1, 0);
    tick();
    chk(d == 0 ? "R4 ab load" : "R7 ba load", get_out(d), 18'h2B6D1);
    set_in(d, 18'h04444);
    repeat (2) tick();
    chk(d == 0 ? "R4 ab no reload on level" : "R7 ba no reload", get_out(d), 18'h2B6D1);
    set_ctl(d, 0, 0, 0);
    tick(); set_ctl(d, 0, 1, 0);
    tick();
    chk(d == 0 ? "R4 ab second load" : "R7 ba second load", get_out(d), 18'h04444);
  endtask

  task automatic t_gate(input int d);
    tick(); set_ctl(d, 0, 0, 1); set_in(d, 18'h3C3C3);
    tick(); set_ctl(d, 0, 1, 1);
    repeat (2) tick();
    chk(d == 0 ? "R5 ab gated edge" : "R7 ba gated edge", get_out(d), 18'h04444);
  endtask

  task automatic t_drive();
    tick(); ab_drv_n = 1; ba_drv_n = 1; #1;
    chk("R6 ab off", {17'd0, b_drv}, '0);
    chk("R6 ba off", {17'd0, a_drv}, '0);
    ab_drv_n = 0; #1;
    chk("R6 ab on", {17'd0, b_drv}, 18'd1);
    chk("R7 ba independent", {17'd0, a_drv}, '0);
    ba_drv_n = 0; #1;
    $display("note: bus conflict, both ports driven; data not compared");
    chk("R6 ba on", {17'd0, a_drv}, 18'd1);
    tick(); ab_drv_n = 1; ba_drv_n = 1;
  endtask

  task automatic t_width();
    tick(); ab_pass = 1; a_in = 18'h20000; #1;
    chk("R1 top bit", b_out, 18'h20000);
    ab_pass = 0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_width();
        for (int d = 0; d < 2; d++) begin
          t_pass(d);
          t_hold(d);
          t_load(d);
          t_gate(d);
        end
        t_drive();
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule